// File: doc/BRIEF.md
# Physical Address Router

This block sits between a minicomputer CPU and its buses. It takes a 22-bit byte address and routes each word or byte access to one of three places: main memory, the 8KB I/O page at the top of the address space, or a non-existent-memory (NXM) abort. Software sets the amount of installed memory in 8KB blocks on `cfg_mem_blk`. The `split_mode` input chooses between two system styles. In one, a single flat backplane carries everything. In the other, a private memory bus runs beside a separate peripheral bus.

In flat mode, every address below the I/O page is memory space, up to 511 blocks (4088KB). In split mode, main memory stops at 480 blocks (3840KB). The window from there up to the I/O page belongs to the peripheral bus. I/O page references in split mode go out on both buses at once. If the memory bus claims one (a memory control register), the peripheral cycle is cancelled and no error is raised.

An accepted access keeps its selects up until a responder acknowledges or a 16-cycle claim timeout expires. Completion is a one-cycle `done` pulse. It carries the read data, the NXM flag, an alignment flag and a peripheral-abort flag.

Top module: `pa_router`

## Requirements
- R1: An address whose top nine bits are all ones (0x3FE000 to 0x3FFFFF) is an I/O page access in both modes: `io_page` and `periph_sel` are high while it is pending.
- R2: In flat mode (`split_mode`=0), an address below `cfg_mem_blk`×8KB and below the I/O page asserts `mem_sel` only. `cfg_mem_blk` may be as large as 511 (4088KB).
- R3: In split mode, main memory is capped at 480 blocks (0x3C0000) whatever `cfg_mem_blk` says. Addresses from 0x3C0000 to 0x3FDFFF assert `periph_sel` only, with `io_page` low.
- R4: In split mode, an I/O page access asserts `mem_sel` and `periph_sel` together.
- R5: If `mem_ack` arrives for a split-mode I/O page access, the access completes with `periph_abort`=1 and `nxm`=0, and its read data comes from `mem_rdata`. This holds even when `periph_ack` is high in the same cycle.
- R6: A memory-space address at or above the configured size, with no peripheral-bus window to catch it, completes with `done` and `nxm` on the cycle after the request. No select is raised.
- R7: If the selected bus gives no acknowledge, the access completes with `nxm` on the 16th clock edge after the request edge.
- R8: Every NXM completion returns `rd_data`=0. `tgt_we` is high only while a select is high, so a request aborted at once never drives a write.
- R9: Byte accesses use address bit 0 to pick the lane. `tgt_be` is 2'b01 for even and 2'b10 for odd. `tgt_wdata` carries the byte on both lanes. A byte read returns the chosen lane in `rd_data[7:0]` with the upper bits zero. Word accesses use `tgt_be`=2'b11.
- R10: A word access with address bit 0 set completes on the next cycle with `align_err`=1 and `nxm`=0, and raises no select.
- R11: An acknowledge sampled at a clock edge gives `done` after that edge, and the selects drop at the same edge. A request presented while an access is pending is ignored.
- R12: After reset, all selects, `done`, the flags and `rd_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| split_mode | input | 1 | 0 = flat backplane, 1 = private memory bus plus peripheral bus |
| cfg_mem_blk | input | 10 | Installed memory in 8KB blocks |
| req_valid | input | 1 | Request strobe, taken when no access is pending |
| req_addr | input | 22 | Physical byte address |
| req_byte | input | 1 | 1 = byte access, 0 = word |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data (byte in bits 7:0 for byte writes) |
| mem_ack | input | 1 | Memory bus claim/acknowledge |
| mem_rdata | input | 16 | Memory bus read data |
| periph_ack | input | 1 | Peripheral bus claim/acknowledge |
| periph_rdata | input | 16 | Peripheral bus read data |
| mem_sel | output | 1 | Memory bus cycle active |
| periph_sel | output | 1 | Peripheral bus cycle active |
| io_page | output | 1 | Pending access targets the I/O page |
| tgt_we | output | 1 | Write strobe to the selected bus |
| tgt_be | output | 2 | Byte-lane enables |
| tgt_wdata | output | 16 | Lane-steered write data |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result, valid with done |
| nxm | output | 1 | Non-existent memory abort, valid with done |
| align_err | output | 1 | Odd word address, valid with done |
| periph_abort | output | 1 | Peripheral cycle cancelled by a memory claim, valid with done |

## Verification
The selects, `io_page` and the write lanes appear right after the edge that accepts a request. An immediate error (NXM or alignment) shows on `done` after that same edge. A claimed access completes after the edge that samples the acknowledge, and an unclaimed one completes 16 edges after acceptance. The bench drives inputs and samples outputs on the falling edge. It counts falling edges from the accepting edge and checks each result exactly at its due edge. For timeouts it also confirms that `done` stays low on the 15 falling edges before.

// File: rtl/pa_router_pkg.sv
// Shared types for the physical address router.
// Assumes: one region code per accepted access, held for the whole bus cycle.
package pa_router_pkg;
    typedef enum logic [1:0] {
        RG_NXM   = 2'd0,   // no responder may exist
        RG_MEM   = 2'd1,   // main memory
        RG_PBMEM = 2'd2,   // peripheral-bus memory window (split mode)
        RG_IOPG  = 2'd3    // top 8KB I/O page
    } region_e;
endpackage

// File: rtl/pa_decode.sv
// Region decoder: classifies an address block number against the bus mode
// and the configured memory size.
// Assumes: block = address divided by the I/O page size; the I/O page is
// the last block; the configured size is clamped to the mode's maximum.
module pa_decode
    import pa_router_pkg::*;
#(
    parameter int BLK_W      = 9,
    parameter int SPLIT_BLKS = 480
) (
    input  logic [BLK_W-1:0] blk,
    input  logic             split,
    input  logic [BLK_W:0]   cfg_blk,
    output region_e          region
);
    localparam logic [BLK_W:0] LAST_BLK  = (BLK_W+1)'((1 << BLK_W) - 1);
    localparam logic [BLK_W:0] SPLIT_TOP = (BLK_W+1)'(SPLIT_BLKS);

    logic [BLK_W:0] mode_top;
    logic [BLK_W:0] limit;
    logic [BLK_W:0] blk_x;

    // Pick the memory ceiling for the mode and classify the block.
    always_comb begin
        mode_top = split ? SPLIT_TOP : LAST_BLK;
        limit    = (cfg_blk < mode_top) ? cfg_blk : mode_top;
        blk_x    = {1'b0, blk};
        if (blk_x == LAST_BLK)
            region = RG_IOPG;
        else if (blk_x < limit)
            region = RG_MEM;
        else if (split && blk_x >= SPLIT_TOP)
            region = RG_PBMEM;
        else
            region = RG_NXM;
    end
endmodule

// File: rtl/pa_claim_timer.sv
// Claim timeout counter: counts cycles of a pending bus access and flags
// the last permitted cycle.
// Assumes: clear pulses when an access is accepted; run is high while it
// is pending; the owner ends the access when expired is seen.
module pa_claim_timer #(
    parameter int TIMEOUT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int            CNT_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count pending cycles, restarting on each new access.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt_q <= '0;
        else if (run && cnt_q != LIMIT)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && (cnt_q == LIMIT);

    AST_TIMER_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !expired) else $error("timer expired right after clear"); // R7
endmodule

// File: rtl/pa_lane.sv
// Byte-lane steering for a two-lane data path: builds lane enables and
// write data, and extracts the read result.
// Assumes: DATA_W is two bytes wide; lsb is address bit 0 of the access.
module pa_lane #(
    parameter int DATA_W = 16
) (
    input  logic              active,
    input  logic              byte_acc,
    input  logic              lsb,
    input  logic              write,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [DATA_W-1:0] rdata_in,
    output logic [1:0]        be,
    output logic [DATA_W-1:0] wdata_out,
    output logic [DATA_W-1:0] rdata_out
);
    localparam int HALF = DATA_W / 2;

    // Lane enables and write data for the pending access only.
    always_comb begin
        if (!active)
            be = 2'b00;
        else if (!byte_acc)
            be = 2'b11;
        else
            be = lsb ? 2'b10 : 2'b01;
        if (!active)
            wdata_out = '0;
        else if (byte_acc)
            wdata_out = {wdata_in[HALF-1:0], wdata_in[HALF-1:0]};
        else
            wdata_out = wdata_in;
    end

    // Read result: chosen byte right-aligned, zero for writes.
    always_comb begin
        if (write)
            rdata_out = '0;
        else if (byte_acc)
            rdata_out = {{HALF{1'b0}}, lsb ? rdata_in[DATA_W-1:HALF] : rdata_in[HALF-1:0]};
        else
            rdata_out = rdata_in;
    end
endmodule

// File: rtl/pa_router.sv
// Physical address router (top): accepts one access at a time, decodes its
// region, drives the bus selects, and finishes on a claim, a timeout,
// or at once on an alignment or out-of-range error.
// Assumes: requests arrive only as req_valid pulses; acks are sampled
// only while the matching select is high.
module pa_router
    import pa_router_pkg::*;
#(
    parameter int ADDR_W     = 22,
    parameter int PAGE_W     = 13,
    parameter int DATA_W     = 16,
    parameter int SPLIT_BLKS = 480,
    parameter int TIMEOUT    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              split_mode,
    input  logic [ADDR_W-PAGE_W:0] cfg_mem_blk,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_byte,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              periph_ack,
    input  logic [DATA_W-1:0] periph_rdata,
    output logic              mem_sel,
    output logic              periph_sel,
    output logic              io_page,
    output logic              tgt_we,
    output logic [1:0]        tgt_be,
    output logic [DATA_W-1:0] tgt_wdata,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              nxm,
    output logic              align_err,
    output logic              periph_abort
);
    localparam int BLK_W = ADDR_W - PAGE_W;

    region_e           dec_region;
    region_e           region_q;
    logic              busy_q, split_q, byte_q, lsb_q, write_q;
    logic [DATA_W-1:0] wdata_q;
    logic              done_q, nxm_q, align_q, abort_q;
    logic [DATA_W-1:0] rd_q;
    logic              accept, odd_word, claim_mem, claim_per, expired;
    logic [DATA_W-1:0] src_rdata, lane_rdata;

    pa_decode #(.BLK_W(BLK_W), .SPLIT_BLKS(SPLIT_BLKS)) u_decode (
        .blk     (req_addr[ADDR_W-1:PAGE_W]),
        .split   (split_mode),
        .cfg_blk (cfg_mem_blk),
        .region  (dec_region)
    );

    pa_claim_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .run     (busy_q),
        .expired (expired)
    );

    // Request acceptance and which responder's claim counts for the region.
    always_comb begin
        accept    = req_valid && !busy_q;
        odd_word  = !req_byte && req_addr[0];
        claim_mem = busy_q && mem_ack &&
                    (region_q == RG_MEM || (region_q == RG_IOPG && split_q));
        claim_per = busy_q && periph_ack &&
                    (region_q == RG_PBMEM || region_q == RG_IOPG);
        src_rdata = claim_mem ? mem_rdata : periph_rdata;
    end

    pa_lane #(.DATA_W(DATA_W)) u_lane (
        .active    (busy_q),
        .byte_acc  (byte_q),
        .lsb       (lsb_q),
        .write     (write_q),
        .wdata_in  (wdata_q),
        .rdata_in  (src_rdata),
        .be        (tgt_be),
        .wdata_out (tgt_wdata),
        .rdata_out (lane_rdata)
    );

    // Access sequencing: accept, wait for a claim or timeout, report once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            region_q <= RG_NXM;
            split_q  <= 1'b0;
            byte_q   <= 1'b0;
            lsb_q    <= 1'b0;
            write_q  <= 1'b0;
            wdata_q  <= '0;
            done_q   <= 1'b0;
            nxm_q    <= 1'b0;
            align_q  <= 1'b0;
            abort_q  <= 1'b0;
            rd_q     <= '0;
        end else begin
            done_q  <= 1'b0;
            nxm_q   <= 1'b0;
            align_q <= 1'b0;
            abort_q <= 1'b0;
            rd_q    <= '0;
            if (accept) begin
                if (odd_word) begin
                    done_q  <= 1'b1;
                    align_q <= 1'b1;
                end else if (dec_region == RG_NXM) begin
                    done_q <= 1'b1;
                    nxm_q  <= 1'b1;
                end else begin
                    busy_q   <= 1'b1;
                    region_q <= dec_region;
                    split_q  <= split_mode;
                    byte_q   <= req_byte;
                    lsb_q    <= req_addr[0];
                    write_q  <= req_write;
                    wdata_q  <= req_wdata;
                end
            end else if (claim_mem || claim_per) begin
                busy_q  <= 1'b0;
                done_q  <= 1'b1;
                rd_q    <= lane_rdata;
                abort_q <= claim_mem && (region_q == RG_IOPG);
            end else if (expired) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
                nxm_q  <= 1'b1;
            end
        end
    end

    // Bus-facing strobes derived from the pending access.
    always_comb begin
        mem_sel    = busy_q && (region_q == RG_MEM || (region_q == RG_IOPG && split_q));
        periph_sel = busy_q && (region_q == RG_PBMEM || region_q == RG_IOPG);
        io_page    = busy_q && (region_q == RG_IOPG);
        tgt_we     = busy_q && write_q;
    end

    assign done         = done_q;
    assign nxm          = nxm_q;
    assign align_err    = align_q;
    assign periph_abort = abort_q;
    assign rd_data      = rd_q;

    AST_IO_ON_PERIPH: assert property (@(posedge clk) disable iff (!rst_n)
        io_page |-> periph_sel) else $error("io page without peripheral select"); // R1
    AST_SPLIT_IO_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (io_page && split_q) |-> mem_sel) else $error("split io page missing memory select"); // R4
    AST_ABORT_NO_NXM: assert property (@(posedge clk) disable iff (!rst_n)
        periph_abort |-> (done && !nxm)) else $error("abort with nxm"); // R5
    AST_NXM_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (done && nxm) |-> (rd_data == '0)) else $error("nxm with data"); // R8
    AST_WE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_we |-> (mem_sel || periph_sel)) else $error("write strobe without select"); // R8
    AST_ODD_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy_q && !req_byte && req_addr[0])
        |=> (done && align_err && !nxm && !mem_sel && !periph_sel))
        else $error("odd word not flagged"); // R10
    AST_SEL_DROP_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && (mem_ack || periph_ack) && (mem_sel || periph_sel) &&
         ((mem_ack && mem_sel) || (periph_ack && periph_sel)))
        |=> (done && !mem_sel && !periph_sel)) else $error("claim did not complete"); // R11
endmodule

// File: tb/pa_router_tb.sv
`timescale 1ns/1ps
// Bench for pa_router: table of vectors walked by one loop, then directed
// tests for reset, writes, busy-ignore and simultaneous claims.
module pa_router_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        split_mode = 1'b0;
    logic [9:0]  cfg_mem_blk = 10'd511;
    logic        req_valid = 1'b0;
    logic [21:0] req_addr = '0;
    logic        req_byte = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        periph_ack = 1'b0;
    logic [15:0] periph_rdata = '0;
    logic        mem_sel, periph_sel, io_page, tgt_we, done, nxm, align_err, periph_abort;
    logic [1:0]  tgt_be;
    logic [15:0] tgt_wdata, rd_data;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pa_router dut_i (
        .clk(clk), .rst_n(rst_n), .split_mode(split_mode), .cfg_mem_blk(cfg_mem_blk),
        .req_valid(req_valid), .req_addr(req_addr), .req_byte(req_byte),
        .req_write(req_write), .req_wdata(req_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .periph_ack(periph_ack), .periph_rdata(periph_rdata),
        .mem_sel(mem_sel), .periph_sel(periph_sel), .io_page(io_page),
        .tgt_we(tgt_we), .tgt_be(tgt_be), .tgt_wdata(tgt_wdata),
        .done(done), .rd_data(rd_data), .nxm(nxm), .align_err(align_err),
        .periph_abort(periph_abort)
    );

    localparam logic [1:0] K_NONE = 2'd0, K_MEM = 2'd1, K_PER = 2'd2, K_NOW = 2'd3;

    typedef struct packed {
        logic        split;
        logic [9:0]  cfg;
        logic [21:0] addr;
        logic        bsz;
        logic [1:0]  kind;
        logic [3:0]  dly;
        logic [15:0] rdat;
        logic        ems, eps, eio, enxm, eal, eab;
        logic [15:0] erd;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b0, 10'd511, 22'h001000, 1'b0, K_MEM,  4'd2, 16'hBEEF, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 16'hBEEF, 4'd2},  // R2
        '{1'b0, 10'd511, 22'h3FC000, 1'b0, K_MEM,  4'd0, 16'h1234, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 16'h1234, 4'd2},  // R2 top of 4088KB
        '{1'b0, 10'd511, 22'h3FFF00, 1'b0, K_PER,  4'd1, 16'h5555, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 16'h5555, 4'd1},  // R1 flat
        '{1'b1, 10'd480, 22'h3FFFE0, 1'b0, K_MEM,  4'd0, 16'h00A5, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b1, 16'h00A5, 4'd5},  // R5
        '{1'b1, 10'd480, 22'h3FFF40, 1'b0, K_PER,  4'd3, 16'h0F0F, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 16'h0F0F, 4'd4},  // R4
        '{1'b1, 10'd511, 22'h3C0000, 1'b0, K_PER,  4'd0, 16'h7E7E, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 16'h7E7E, 4'd3},  // R3
        '{1'b1, 10'd480, 22'h3BFFFE, 1'b0, K_MEM,  4'd1, 16'hC0DE, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 16'hC0DE, 4'd3},  // R3 below cap
        '{1'b0, 10'd256, 22'h200000, 1'b0, K_NOW,  4'd0, 16'hFFFF, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 16'h0000, 4'd6},  // R6
        '{1'b0, 10'd256, 22'h1FFFFE, 1'b0, K_MEM,  4'd0, 16'h4242, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 16'h4242, 4'd6},  // R6 edge
        '{1'b0, 10'd511, 22'h000101, 1'b0, K_NOW,  4'd0, 16'hFFFF, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 16'h0000, 4'd10}, // R10
        '{1'b0, 10'd511, 22'h000101, 1'b1, K_MEM,  4'd0, 16'hAB12, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 16'h00AB, 4'd9},  // R9 odd
        '{1'b0, 10'd511, 22'h000100, 1'b1, K_MEM,  4'd0, 16'hAB12, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 16'h0012, 4'd9},  // R9 even
        '{1'b0, 10'd511, 22'h3FE000, 1'b0, K_NONE, 4'd0, 16'h9999, 1'b0,1'b1,1'b1,1'b1,1'b0,1'b0, 16'h0000, 4'd7},  // R7 io timeout
        '{1'b1, 10'd64,  22'h100000, 1'b0, K_NOW,  4'd0, 16'hFFFF, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 16'h0000, 4'd6},  // R6 split
        '{1'b1, 10'd480, 22'h000200, 1'b0, K_NONE, 4'd0, 16'h1111, 1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 16'h0000, 4'd7}   // R7 mem timeout
    };

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic put_req(input logic [21:0] a, input logic b, input logic w, input logic [15:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_byte = b; req_write = w; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic run_vec(input vec_t v);
        string tag;
        bit    early;
        tag = $sformatf("R%0d", v.req);
        split_mode = v.split; cfg_mem_blk = v.cfg;
        mem_rdata    = (v.kind == K_PER) ? 16'hDEAD : v.rdat;
        periph_rdata = (v.kind == K_MEM) ? 16'hDEAD : v.rdat;
        put_req(v.addr, v.bsz, 1'b0, 16'h0);
        chk(tag, "mem_sel", mem_sel, v.ems);
        chk(tag, "periph_sel", periph_sel, v.eps);
        chk(tag, "io_page", io_page, v.eio);
        if (v.kind == K_NOW) begin
            chk(tag, "done", done, 1);
        end else if (v.kind == K_NONE) begin
            early = 1'b0;
            for (int i = 1; i < 16; i++) begin
                @(negedge clk);
                if (done) early = 1'b1;
            end
            chk(tag, "done before timeout", early, 0);
            @(negedge clk);
            chk(tag, "done at timeout", done, 1);
        end else begin
            repeat (v.dly) @(negedge clk);
            chk(tag, "done before ack", done, 0);
            if (v.kind == K_MEM) mem_ack = 1'b1; else periph_ack = 1'b1;
            @(negedge clk);
            mem_ack = 1'b0; periph_ack = 1'b0;
            chk(tag, "done", done, 1);
            chk(tag, "selects dropped", {mem_sel, periph_sel}, 0);
        end
        chk(tag, "nxm", nxm, v.enxm);
        chk(tag, "align_err", align_err, v.eal);
        chk(tag, "periph_abort", periph_abort, v.eab);
        chk(tag, "rd_data", rd_data, v.erd);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R11 watchdog actual=hung expected=complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit seen;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12", "outputs at reset",
            {mem_sel, periph_sel, io_page, tgt_we, done, nxm, align_err, periph_abort, tgt_be, rd_data}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R9: odd byte write steers the byte to the upper lane
        split_mode = 1'b0; cfg_mem_blk = 10'd511;
        put_req(22'h000011, 1'b1, 1'b1, 16'h3377);
        chk("R9", "tgt_we", tgt_we, 1);
        chk("R9", "tgt_be odd", tgt_be, 2'b10);
        chk("R9", "tgt_wdata", tgt_wdata, 16'h7777);
        mem_ack = 1'b1; @(negedge clk); mem_ack = 1'b0;
        chk("R9", "write rd_data", rd_data, 0);
        @(negedge clk);

        // R9: word write uses both lanes
        put_req(22'h000020, 1'b0, 1'b1, 16'hA1B2);
        chk("R9", "tgt_be word", tgt_be, 2'b11);
        chk("R9", "tgt_wdata word", tgt_wdata, 16'hA1B2);
        mem_ack = 1'b1; @(negedge clk); mem_ack = 1'b0;
        @(negedge clk);

        // R8: write beyond configured size never strobes
        cfg_mem_blk = 10'd8;
        put_req(22'h020000, 1'b0, 1'b1, 16'h5A5A);
        chk("R8", "no write strobe on nxm", {tgt_we, mem_sel, periph_sel}, 0);
        chk("R8", "nxm", nxm, 1);
        @(negedge clk);

        // R11: request during a pending access is ignored
        cfg_mem_blk = 10'd511;
        mem_rdata = 16'h0C0C;
        put_req(22'h000040, 1'b0, 1'b0, 16'h0);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 22'h000101; req_byte = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11", "busy ignores request", {done, align_err}, 0);
        mem_ack = 1'b1; @(negedge clk); mem_ack = 1'b0;
        chk("R11", "original completes", {done, align_err, rd_data}, {2'b10, 16'h0C0C});
        seen = 1'b0;
        repeat (3) begin @(negedge clk); if (done) seen = 1'b1; end
        chk("R11", "no second completion", seen, 0);

        // R5: simultaneous claims on a split io page access, memory wins
        split_mode = 1'b1; mem_rdata = 16'h1357; periph_rdata = 16'h2468;
        put_req(22'h3FFFF0, 1'b0, 1'b0, 16'h0);
        mem_ack = 1'b1; periph_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0; periph_ack = 1'b0;
        chk("R5", "memory wins", {done, periph_abort, nxm, rd_data}, {3'b110, 16'h1357});
        @(negedge clk);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule